// File: doc/BRIEF.md
# Committed-Store Drain Buffer

This block sits between instruction commit and the data cache. Commit hands it stores in program order; the moment a store is accepted it is considered committed, so commit can move on even if the cache is busy or the line misses. The buffer then writes its entries to the cache strictly oldest first, one at a time, over a request/acknowledge handshake. An entry is released only when the cache acknowledges the write.

Until an entry has been written, the buffer belongs to the cache hierarchy: a load presents its address on a lookup port and receives, in the same cycle, a hit flag and the data of the youngest resident store to that address. Older stores to the same address are hidden by the younger one. When every slot is occupied the buffer raises a full flag and refuses new stores, stalling commit until the cache drains an entry.

Top module: `wb_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_full` is 0, `wr_req` is 0 and `ld_hit` is 0 for any lookup address.
- R2: A store is accepted on a rising clock edge where `st_valid` is 1 and `st_full` is 0; accepted stores are presented to the cache in exactly the order they were accepted, each once.
- R3: With DEPTH entries resident `st_full` is 1, and a store offered then is discarded: it never reaches the cache and never hits a lookup.
- R4: `wr_req` is 1 whenever at least one entry is resident, and `wr_addr`/`wr_data` then carry the oldest resident entry.
- R5: While `wr_req` is 1 and `wr_ack` is 0, `wr_req`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R6: An entry is released on a rising edge where `wr_req` and `wr_ack` are both 1; a full buffer drained this way drops `st_full` in the next cycle.
- R7: `ld_hit` is 1 in the same cycle that `ld_addr` equals the address of any resident entry, and `ld_data` is then the data of the most recently accepted of the matching entries.
- R8: Once the last resident entry for an address is released, a lookup of that address returns `ld_hit` 0.
- R9: A store being accepted in the current cycle is not visible to a lookup in that same cycle.
- R10: A store accepted in the same cycle as a release leaves the number of resident entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Commit offers a store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_full | output | 1 | All slots occupied; offered stores are refused |
| wr_req | output | 1 | Write of the oldest entry is pending |
| wr_addr | output | ADDR_W | Address of the oldest entry |
| wr_data | output | DATA_W | Data of the oldest entry |
| wr_ack | input | 1 | Cache has completed the pending write |
| ld_addr | input | ADDR_W | Load lookup address |
| ld_hit | output | 1 | A resident entry matches `ld_addr` |
| ld_data | output | DATA_W | Data of the youngest matching entry |

## Verification
The bench builds the buffer with DEPTH 4, an 8-bit address and 16-bit data. The short depth lets the full stall, refusal of an extra store and release-while-full be reached within a few cycles, and lets the ring pointers wrap many times during a long mixed run. The narrow address space, with stores drawn from only eight addresses, makes several resident entries share an address so that youngest-match priority and post-release misses are exercised constantly, including matches that straddle the pointer wrap.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

   // Width of a counter able to hold the values 0 .. n.
   function automatic int unsigned wbb_cnt_bits(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // Width of an index into n slots.
   function automatic int unsigned wbb_idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wbb_ring.sv
module wbb_ring
   import wbb_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 64,
   localparam int unsigned PTR_W = wbb_idx_bits(DEPTH),
   localparam int unsigned CNT_W = wbb_cnt_bits(DEPTH)
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [ADDR_W-1:0]             push_addr,
   input  logic [DATA_W-1:0]             push_data,
   input  logic                          pop,
   output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
   output logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
   output logic [PTR_W-1:0]              head,
   output logic [CNT_W-1:0]              fill,
   output logic                          full,
   output logic                          empty
);

   logic [PTR_W-1:0] tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         fill <= '0;
      end else begin
         if (push) tail <= tail + PTR_W'(1);
         if (pop)  head <= head + PTR_W'(1);
         case ({push, pop})
            2'b10:   fill <= fill + CNT_W'(1);
            2'b01:   fill <= fill - CNT_W'(1);
            default: fill <= fill;
         endcase
      end
   end

   // Payload storage carries no reset: a slot is only read while resident.
   always_ff @(posedge clk) begin
      if (push) begin
         slot_addr[tail] <= push_addr;
         slot_data[tail] <= push_data;
      end
   end

   assign full  = (fill == CNT_W'(DEPTH));
   assign empty = (fill == '0);

   // R3: the owner must never push into a full ring unless a slot frees.
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |-> !push);

   // R6: a release is only ever requested for a resident entry.
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

   // R10: simultaneous push and pop leaves the occupancy alone.
   p_fill_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(fill));

endmodule

// File: rtl/wbb_youngest_hit.sv
module wbb_youngest_hit
   import wbb_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 64,
   localparam int unsigned PTR_W = wbb_idx_bits(DEPTH),
   localparam int unsigned CNT_W = wbb_cnt_bits(DEPTH)
)(
   input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
   input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
   input  logic [PTR_W-1:0]              head,
   input  logic [CNT_W-1:0]              fill,
   input  logic [ADDR_W-1:0]             probe_addr,
   output logic                          hit,
   output logic [DATA_W-1:0]             hit_data
);

   // Per-slot compare, qualified by residency (slot age below occupancy).
   logic [DEPTH-1:0] slot_match;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PTR_W-1:0] age;
      assign age           = PTR_W'(i) - head;
      assign slot_match[i] = (CNT_W'(age) < fill) && (slot_addr[i] == probe_addr);
   end

   // Walk from oldest to youngest; the last match seen wins.
   always_comb begin
      hit      = 1'b0;
      hit_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         logic [PTR_W-1:0] idx;
         idx = head + PTR_W'(k);
         if (slot_match[idx]) begin
            hit      = 1'b1;
            hit_data = slot_data[idx];
         end
      end
   end

endmodule

// File: rtl/wb_store_buffer.sv
module wb_store_buffer
   import wbb_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 64
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               st_valid,
   input  logic [ADDR_W-1:0]  st_addr,
   input  logic [DATA_W-1:0]  st_data,
   output logic               st_full,
   output logic               wr_req,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [DATA_W-1:0]  wr_data,
   input  logic               wr_ack,
   input  logic [ADDR_W-1:0]  ld_addr,
   output logic               ld_hit,
   output logic [DATA_W-1:0]  ld_data
);

   localparam int unsigned PTR_W = wbb_idx_bits(DEPTH);
   localparam int unsigned CNT_W = wbb_cnt_bits(DEPTH);

   // Elaboration checks: the ring wraps by truncation, so depth is a power of two.
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wb_store_buffer: DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("wb_store_buffer: ADDR_W and DATA_W must be non-zero");
   end

   logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
   logic [DEPTH-1:0][DATA_W-1:0] slot_data;
   logic [PTR_W-1:0]             head;
   logic [CNT_W-1:0]             fill;
   logic                         full, empty;
   logic                         accept, release_slot;

   assign accept       = st_valid && !full;
   assign release_slot = wr_req && wr_ack;

   wbb_ring #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (release_slot),
      .slot_addr (slot_addr),
      .slot_data (slot_data),
      .head      (head),
      .fill      (fill),
      .full      (full),
      .empty     (empty)
   );

   wbb_youngest_hit #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hit (
      .slot_addr  (slot_addr),
      .slot_data  (slot_data),
      .head       (head),
      .fill       (fill),
      .probe_addr (ld_addr),
      .hit        (ld_hit),
      .hit_data   (ld_data)
   );

   assign st_full = full;
   assign wr_req  = !empty;
   assign wr_addr = slot_addr[head];
   assign wr_data = slot_data[head];

   // R5: an unacknowledged write request holds still.
   p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   // R2: a store into an empty buffer is the next write presented.
   p_enq_to_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_req && st_valid) |=> (wr_req && wr_addr == $past(st_addr)
                                  && wr_data == $past(st_data)));

   // R6: draining a full buffer clears the stall next cycle.
   p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_full && wr_req && wr_ack) |=> !st_full);

   // R8: nothing resident means no lookup can hit.
   p_no_hit_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |-> !ld_hit);

   // R4: releasing the only entry with no new store empties the buffer.
   p_last_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (release_slot && fill == CNT_W'(1) && !st_valid) |=> !wr_req);

endmodule

// File: tb/sim_wb_store_buffer.sv
module sim_wb_store_buffer;

   localparam int unsigned DEPTH  = 4;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned DATA_W = 16;

   typedef struct packed {
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              st_valid = 1'b0;
   logic [ADDR_W-1:0] st_addr = '0;
   logic [DATA_W-1:0] st_data = '0;
   logic              st_full;
   logic              wr_req;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              wr_ack = 1'b0;
   logic [ADDR_W-1:0] ld_addr = '0;
   logic              ld_hit;
   logic [DATA_W-1:0] ld_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Scoreboard: resident stores, oldest at the front.
   item_t res_q[$];

   always #5 clk = ~clk;

   wb_store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_full(st_full),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Monitor: at negedge+2 the inputs of this cycle are settled; a handshake
   // seen now completes at the next edge, so compare and retire the oldest item.
   logic              prev_wait = 1'b0;
   logic [ADDR_W-1:0] prev_addr = '0;
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(wr_req == (res_q.size() != 0), "R4 wr_req vs occupancy",
               32'(wr_req), 32'(res_q.size() != 0));
         if (prev_wait && wr_req)
            check(wr_addr == prev_addr, "R5 address held", 32'(wr_addr), 32'(prev_addr));
         if (wr_req && res_q.size() != 0) begin
            check(wr_addr == res_q[0].a, "R2 R4 drain address order",
                  32'(wr_addr), 32'(res_q[0].a));
            check(wr_data == res_q[0].d, "R2 R4 drain data order",
                  32'(wr_data), 32'(res_q[0].d));
         end
         if (wr_req && wr_ack && res_q.size() != 0) void'(res_q.pop_front());
         prev_wait = wr_req && !wr_ack;
         prev_addr = wr_addr;
      end
   end

   // Driver: one cycle of stimulus. Lookup and full checks use the state
   // before this cycle's edge; an accepted store joins the scoreboard after the
   // monitor has retired this cycle's release.
   task automatic step(input bit sv, input logic [ADDR_W-1:0] sa,
                       input logic [DATA_W-1:0] sd, input bit ack,
                       input logic [ADDR_W-1:0] la, input string tag);
      bit exp_hit;
      logic [DATA_W-1:0] exp_d;
      bit exp_full;
      @(negedge clk);
      st_valid = sv; st_addr = sa; st_data = sd; wr_ack = ack; ld_addr = la;
      #1;
      exp_hit = 1'b0; exp_d = '0;
      foreach (res_q[i]) if (res_q[i].a == la) begin exp_hit = 1'b1; exp_d = res_q[i].d; end
      exp_full = (res_q.size() == DEPTH);
      check(ld_hit == exp_hit, {tag, " R7 R8 R9 hit"}, 32'(ld_hit), 32'(exp_hit));
      if (exp_hit) check(ld_data == exp_d, {tag, " R7 youngest data"}, 32'(ld_data), 32'(exp_d));
      check(st_full == exp_full, {tag, " R3 R6 full flag"}, 32'(st_full), 32'(exp_full));
      #2;
      if (sv && !exp_full) res_q.push_back('{a: sa, d: sd});
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(st_full == 1'b0, "R1 full after reset", 32'(st_full), 0);
      check(wr_req == 1'b0, "R1 wr_req after reset", 32'(wr_req), 0);
      check(ld_hit == 1'b0, "R1 no hit after reset", 32'(ld_hit), 0);
      rst_n = 1'b1;

      // R9: a store and a lookup to the same address in one cycle: no hit yet.
      step(1, 8'h42, 16'h1111, 0, 8'h42, "R9 same-cycle");
      step(0, 0, 0, 0, 8'h42, "R7 first visible");
      // Fill with duplicates of 0x42; the youngest must win (R7).
      step(1, 8'h42, 16'h2222, 0, 8'h42, "R7 dup");
      step(1, 8'h17, 16'h3333, 0, 8'h42, "R7 other");
      step(1, 8'h42, 16'h4444, 0, 8'h42, "R7 dup2");
      // Now full; R3: this store must be refused and never seen.
      step(1, 8'h99, 16'hDEAD, 0, 8'h99, "R3 refused");
      step(1, 8'h99, 16'hBEEF, 0, 8'h99, "R3 refused2");
      // R5: hold without ack for a few cycles.
      repeat (3) step(0, 0, 0, 0, 8'h17, "R5 hold");
      // R6: release while full, store in the same cycle is still refused.
      step(1, 8'h99, 16'h0BAD, 1, 8'h42, "R6 release full");
      step(0, 0, 0, 0, 8'h99, "R3 R6 after release");
      // R10: store and release together.
      step(1, 8'h17, 16'h5555, 1, 8'h17, "R10 push pop");
      step(0, 0, 0, 0, 8'h17, "R10 after");
      // Drain everything; R8: addresses stop hitting.
      repeat (6) step(0, 0, 0, 1, 8'h42, "R8 drain 42");
      step(0, 0, 0, 0, 8'h17, "R8 gone 17");

      // Mixed run: narrow address range, random acks, many wraps.
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 3) != 0, 8'($urandom % 8), 16'($urandom),
              ($urandom % 2) == 1, 8'($urandom % 8), "mixed");
      end
      repeat (8) step(0, 0, 0, 1, 8'($urandom % 8), "R8 final drain");
      step(0, 0, 0, 0, 8'h03, "R8 empty end");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule